// File: doc/BRIEF.md
# Free-Memory Occupancy Histogram Profiler

This block watches a buffer's free-memory level on every clock and builds a histogram of time against occupancy. The full memory span is divided into a run-time chosen number of equal-width ranges. Each clock of an active run adds one to the counter of the range that holds the sampled level. A total cycle counter runs alongside the bin counters. The fraction of time spent in any range is that bin's count divided by the total.

Software or a test harness sets the number of ranges and pulses start. It lets traffic flow, then pulses stop. It then reads each bin by index through a registered read port. A second counter records the run cycles in which a link-busy input was high, which gives a utilisation figure at the monitored point. A clear pulse zeroes every counter so that a new run can begin.

Top module: `fmem_histo_profiler`

## Requirements
- R1: The bin count is latched from `binCfg` on a start pulse while idle. A value of 0 is taken as 1, and any value above 16 is taken as 16. Changes to `binCfg` during a run have no effect.
- R2: With n bins, the bin width is W = ceil(MEM_BYTES / n). A level L is counted in bin min(floor(L / W), n-1), so levels above MEM_BYTES fall into the last bin.
- R3: While no counter has saturated, the sum of all bin counts equals `totalCycles`.
- R4: Counting begins on the clock after the edge that samples start. The edge that samples stop is the last one counted. Levels presented while idle are not counted.
- R5: Every counter (bins, total, busy) is CNT_W bits wide (32 by default) and holds at its all-ones value instead of wrapping.
- R6: A clear pulse zeroes all counters and ends any run. Clear has priority over start and stop.
- R7: `rdData` presents the count of bin `rdIdx` one clock after `rdIdx` is sampled. An index at or above the active bin count reads as 0.
- R8: `busyCycles` counts the run cycles in which `linkBusy` is high.
- R9: After reset the block is idle, with all counters at 0 and one bin configured.
- R10: A start pulse during a run is ignored. The configuration is kept and counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startRun | input | 1 | Begin a profiling run (ignored while running) |
| stopRun | input | 1 | End the current run |
| clearAll | input | 1 | Zero all counters and end the run |
| binCfg | input | $clog2(MAX_BINS)+1 | Requested number of bins |
| freeLevel | input | $clog2(MEM_BYTES+1) | Free-memory level sampled every clock |
| linkBusy | input | 1 | Link carries data this cycle |
| rdIdx | input | $clog2(MAX_BINS) | Bin to read |
| rdData | output | CNT_W | Registered count of the selected bin |
| totalCycles | output | CNT_W | Cycles counted in runs since the last clear |
| busyCycles | output | CNT_W | Run cycles with the link busy |
| running | output | 1 | A run is active |

## Verification
The assertions assume that the control inputs are driven to known values from reset onward. They also assume that `freeLevel` is a defined number on every clock, so that exactly one bin is hit per counted cycle. The sum check is valid only while the total counter is below saturation. The bench therefore keeps runs to a few dozen cycles on the 32-bit instance, and it exercises saturation only on a narrow second instance. It changes the inputs only between edges, and it pulses start, stop and clear for single cycles.

// File: rtl/fmem_histo_pkg.sv
package fmem_histo_pkg;
  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } ctlStrobes_t;
endpackage

// File: rtl/fmem_histo_ctrl.sv
module fmem_histo_ctrl
  import fmem_histo_pkg::*;
#(
  parameter int MAX_BINS = 16,
  localparam int IDX_W = $clog2(MAX_BINS),
  localparam int CFG_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRun,
  input  logic             stopRun,
  input  logic             clearAll,
  input  logic [CFG_W-1:0] binCfg,
  output logic             running,
  output logic [IDX_W-1:0] cfgM1,
  output ctlStrobes_t      strb
);

  logic [IDX_W-1:0] cfgClamped;

  always_comb begin
    if (binCfg == '0) cfgClamped = '0;
    else if (int'(binCfg) > MAX_BINS) cfgClamped = IDX_W'(MAX_BINS - 1);
    else cfgClamped = IDX_W'(int'(binCfg) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cfgM1   <= '0;
    end else if (clearAll) begin
      running <= 1'b0;
    end else if (running) begin
      if (stopRun) running <= 1'b0;
    end else if (startRun) begin
      running <= 1'b1;
      cfgM1   <= cfgClamped;
    end
  end

  always_comb begin
    strb.clearCnt = clearAll;
    strb.countEn  = running && !clearAll;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> $stable(cfgM1)); // R1
  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> !running); // R6

endmodule

// File: rtl/fmem_histo_datapath.sv
module fmem_histo_datapath
  import fmem_histo_pkg::*;
#(
  parameter int MEM_BYTES = 8192,
  parameter int MAX_BINS  = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W   = $clog2(MAX_BINS),
  localparam int LEVEL_W = $clog2(MEM_BYTES + 1),
  localparam int WID_W   = LEVEL_W + 1,
  localparam int SUM_W   = CNT_W + IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [IDX_W-1:0]   cfgM1,
  input  logic [LEVEL_W-1:0] freeLevel,
  input  logic               linkBusy,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [CNT_W-1:0]   rdData,
  output logic [CNT_W-1:0]   totalCycles,
  output logic [CNT_W-1:0]   busyCycles
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WID_W-1:0]    widthTab [MAX_BINS];
  logic [WID_W-1:0]    curWidth;
  logic [IDX_W-1:0]    binIdx;
  logic [MAX_BINS-1:0] binInc;
  logic [CNT_W-1:0]    binCnt [MAX_BINS];
  logic [SUM_W-1:0]    sumAll;

  // one constant width per possible bin count: ceil(MEM_BYTES / n)
  for (genvar g = 0; g < MAX_BINS; g++) begin : gWidth
    localparam int BW = (MEM_BYTES + g) / (g + 1);
    assign widthTab[g] = WID_W'(BW);
  end

  assign curWidth = widthTab[cfgM1];

  // thresholds k*W rise with k, so the last one reached names the bin
  always_comb begin
    binIdx = '0;
    for (int k = 1; k < MAX_BINS; k++) begin
      if (k <= int'(cfgM1) && int'(freeLevel) >= k * int'(curWidth))
        binIdx = IDX_W'(k);
    end
  end

  always_comb begin
    binInc = '0;
    if (strb.countEn) binInc[binIdx] = 1'b1;
  end

  for (genvar g = 0; g < MAX_BINS; g++) begin : gBin
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearCnt) binCnt[g] <= '0;
      else if (binInc[g] && binCnt[g] != CNT_MAX) binCnt[g] <= binCnt[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearCnt) begin
      totalCycles <= '0;
      busyCycles  <= '0;
    end else if (strb.countEn) begin
      if (totalCycles != CNT_MAX) totalCycles <= totalCycles + 1'b1;
      if (linkBusy && busyCycles != CNT_MAX) busyCycles <= busyCycles + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdIdx <= cfgM1) rdData <= binCnt[rdIdx];
    else rdData <= '0;
  end

  always_comb begin
    sumAll = '0;
    for (int k = 0; k < MAX_BINS; k++) sumAll = sumAll + SUM_W'(binCnt[k]);
  end

  AST_ONE_BIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.countEn |-> $countones(binInc) == 1); // R2
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (totalCycles != CNT_MAX) |-> sumAll == SUM_W'(totalCycles)); // R3
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (totalCycles == CNT_MAX && !strb.clearCnt) |=> totalCycles == CNT_MAX); // R5
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (totalCycles == '0 && busyCycles == '0)); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyCycles <= totalCycles); // R8

endmodule

// File: rtl/fmem_histo_profiler.sv
module fmem_histo_profiler
  import fmem_histo_pkg::*;
#(
  parameter int MEM_BYTES = 8192,
  parameter int MAX_BINS  = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W   = $clog2(MAX_BINS),
  localparam int CFG_W   = IDX_W + 1,
  localparam int LEVEL_W = $clog2(MEM_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startRun,
  input  logic               stopRun,
  input  logic               clearAll,
  input  logic [CFG_W-1:0]   binCfg,
  input  logic [LEVEL_W-1:0] freeLevel,
  input  logic               linkBusy,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [CNT_W-1:0]   rdData,
  output logic [CNT_W-1:0]   totalCycles,
  output logic [CNT_W-1:0]   busyCycles,
  output logic               running
);

  ctlStrobes_t      strb;
  logic [IDX_W-1:0] cfgM1;

  fmem_histo_ctrl #(.MAX_BINS(MAX_BINS)) uCtrl (
    .clk(clk), .rstN(rstN), .startRun(startRun), .stopRun(stopRun),
    .clearAll(clearAll), .binCfg(binCfg), .running(running),
    .cfgM1(cfgM1), .strb(strb)
  );

  fmem_histo_datapath #(.MEM_BYTES(MEM_BYTES), .MAX_BINS(MAX_BINS), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgM1(cfgM1),
    .freeLevel(freeLevel), .linkBusy(linkBusy), .rdIdx(rdIdx),
    .rdData(rdData), .totalCycles(totalCycles), .busyCycles(busyCycles)
  );

endmodule

// File: tb/sim_fmem_histo_profiler.sv
module sim_fmem_histo_profiler;
  localparam int MEM = 8192;
  localparam int LW  = $clog2(MEM + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startRun = 1'b0, stopRun = 1'b0, clearAll = 1'b0, linkBusy = 1'b0;
  logic [4:0] binCfg = '0;
  logic [LW-1:0] freeLevel = '0;
  logic [3:0] rdIdx = '0;
  logic [31:0] rdData, totalCycles, busyCycles;
  logic running;
  logic [3:0] sRd, sTot, sBusy;
  logic sRun;

  int nTests = 0, nFail = 0;
  bit done = 0;
  longint expBin [16];
  longint expTot = 0, expBusy = 0;
  int curBins = 1;
  int lvBuf [64];
  bit bzBuf [64];

  always #10 clk = ~clk;

  fmem_histo_profiler u0 (
    .clk(clk), .rstN(rstN), .startRun(startRun), .stopRun(stopRun),
    .clearAll(clearAll), .binCfg(binCfg), .freeLevel(freeLevel),
    .linkBusy(linkBusy), .rdIdx(rdIdx), .rdData(rdData),
    .totalCycles(totalCycles), .busyCycles(busyCycles), .running(running)
  );

  fmem_histo_profiler #(.CNT_W(4)) uSat (
    .clk(clk), .rstN(rstN), .startRun(startRun), .stopRun(stopRun),
    .clearAll(clearAll), .binCfg(binCfg), .freeLevel(freeLevel),
    .linkBusy(linkBusy), .rdIdx(rdIdx), .rdData(sRd),
    .totalCycles(sTot), .busyCycles(sBusy), .running(sRun)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < 16; i++) expBin[i] = 0;
    expTot = 0; expBusy = 0;
  endtask

  task automatic doClear();
    clearAll = 1'b1; @(negedge clk); clearAll = 1'b0;
    modelClear();
  endtask

  function automatic int effBins(input int c);
    if (c == 0) return 1;
    if (c > 16) return 16;
    return c;
  endfunction

  function automatic int refBin(input int lvl, input int n);
    int w = (MEM + n - 1) / n;
    int b = lvl / w;
    return (b > n - 1) ? n - 1 : b;
  endfunction

  // start, feed n samples (stop with the last), update model
  task automatic doRun(input int cfg, input int n);
    binCfg = 5'(cfg); startRun = 1'b1; @(negedge clk); startRun = 1'b0;
    curBins = effBins(cfg);
    for (int i = 0; i < n; i++) begin
      freeLevel = LW'(lvBuf[i]); linkBusy = bzBuf[i];
      stopRun = (i == n - 1);
      @(negedge clk);
      expBin[refBin(lvBuf[i], curBins)]++;
      expTot++;
      if (bzBuf[i]) expBusy++;
    end
    stopRun = 1'b0; linkBusy = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    for (int b = 0; b < 16; b++) begin
      rdIdx = 4'(b); @(negedge clk);
      chk($sformatf("%s bin%0d", tag, b), rdData, (b < curBins) ? expBin[b] : 0);
    end
    chk({tag, " total"}, totalCycles, expTot);
  endtask

  task automatic tReset();
    chk("R9 running", running, 0);
    chk("R9 total", totalCycles, 0);
    chk("R9 busy", busyCycles, 0);
    rdIdx = 0; @(negedge clk);
    chk("R9 bin0", rdData, 0);
  endtask

  task automatic tFourBins();
    int lv[8] = '{0, 2047, 2048, 4095, 4096, 8191, 8192, 16383};
    doClear();
    for (int i = 0; i < 8; i++) begin lvBuf[i] = lv[i]; bzBuf[i] = 0; end
    doRun(4, 8);
    chk("R4 stopped", running, 0);
    checkAll("R2 n4");
  endtask

  task automatic tThreeBins();
    int lv[6] = '{2730, 2731, 5461, 5462, 0, 8192};
    doClear();
    for (int i = 0; i < 6; i++) begin lvBuf[i] = lv[i]; bzBuf[i] = 0; end
    doRun(3, 6);
    checkAll("R2 n3");
  endtask

  task automatic tSixteenAndClamp();
    int lv[5] = '{0, 511, 512, 7679, 7680};
    doClear();
    for (int i = 0; i < 5; i++) begin lvBuf[i] = lv[i]; bzBuf[i] = 0; end
    doRun(20, 5);
    checkAll("R1 cfg20");
    doClear();
    doRun(0, 5);
    checkAll("R1 cfg0");
    rdIdx = 4'd3; @(negedge clk);
    chk("R7 idx beyond", rdData, 0);
  endtask

  task automatic tIdleIgnored();
    doClear();
    for (int i = 0; i < 5; i++) begin freeLevel = LW'(i * 1000); linkBusy = 1; @(negedge clk); end
    linkBusy = 0;
    chk("R4 idle total", totalCycles, 0);
    chk("R4 idle busy", busyCycles, 0);
  endtask

  task automatic tBusyAndSum();
    doClear();
    for (int i = 0; i < 20; i++) begin lvBuf[i] = (i * 431) % 9000; bzBuf[i] = (i % 3) != 0; end
    doRun(7, 20);
    chk("R8 busy", busyCycles, expBusy);
    checkAll("R3 sum n7");
    doRun(7, 10);
    checkAll("R3 accumulate");
  endtask

  task automatic tStartDuringRun();
    doClear();
    binCfg = 5'd2; startRun = 1'b1; @(negedge clk); startRun = 1'b0;
    curBins = 2;
    freeLevel = LW'(5000); @(negedge clk); expBin[1]++; expTot++;
    binCfg = 5'd8; startRun = 1'b1; freeLevel = LW'(5000); @(negedge clk);
    startRun = 1'b0; expBin[1]++; expTot++;
    chk("R10 still running", running, 1);
    stopRun = 1'b1; freeLevel = LW'(100); @(negedge clk); stopRun = 1'b0;
    expBin[0]++; expTot++;
    checkAll("R10 cfg kept");
  endtask

  task automatic tClearMidRun();
    doClear();
    binCfg = 5'd4; startRun = 1'b1; @(negedge clk); startRun = 1'b0;
    repeat (5) @(negedge clk);
    clearAll = 1'b1; startRun = 1'b1; @(negedge clk); clearAll = 1'b0; startRun = 1'b0;
    modelClear();
    chk("R6 run ended", running, 0);
    chk("R6 total zero", totalCycles, 0);
    curBins = 4;
    checkAll("R6 bins zero");
  endtask

  task automatic tSaturate();
    doClear();
    for (int i = 0; i < 20; i++) begin lvBuf[i] = 100; bzBuf[i] = 1; end
    doRun(1, 20);
    chk("R5 sat total", sTot, 15);
    chk("R5 sat busy", sBusy, 15);
    rdIdx = 0; @(negedge clk);
    chk("R5 sat bin0", sRd, 15);
    chk("R5 wide total", totalCycles, 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFourBins();
    tThreeBins();
    tSixteenAndClamp();
    tIdleIgnored();
    tBusyAndSum();
    tStartDuringRun();
    tClearMidRun();
    tSaturate();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule